// File: doc/BRIEF.md
# Edge-Triggered Priority Interrupt Controller

This block collects up to eight interrupt sources for a small CPU. A rising edge on a request line latches a pending bit. The pending bit stays latched even when that line is masked. The highest-priority request that is pending, unmasked and above everything already in service raises `intr`. The CPU answers with a one-cycle acknowledge pulse. On that pulse the controller moves the winning level from the pending set into the in-service set and returns an 8-bit vector built from a programmable base and the level number.

The CPU reaches the block through a byte-wide port with two addresses, selected by `cpuSel`. The command address (`cpuSel`=0) accepts three kinds of byte:
- an initialization byte,
- a read-select command,
- a non-specific end-of-interrupt.

The mask address (`cpuSel`=1) writes and reads the mask.

A mask write holds `intr` low until the CPU has signalled one instruction boundary. The read that follows a mask write therefore always sees the value just written, even if a pending request was unmasked.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service registers are 0x00, `intr` is low, and the command address reads the pending register.
- R2: A 0-to-1 transition on `reqIn[n]` sets pending bit n whether or not mask bit n is set. A line held high does not set the bit again after it has been cleared.
- R3: A masked pending request stays latched. Clearing its mask bit makes it able to raise `intr`.
- R4: Level 0 has the highest priority and level 7 the lowest. `intr` is high only when some pending, unmasked level is of higher priority than every in-service level.
- R5: On an `intAck` pulse while a request qualifies, the winning pending bit is cleared and its in-service bit is set. From the next cycle `vector` = {base[2:0], 2'b00, level[2:0]}. With no qualifying request, `vector` gives level 7 and no register changes.
- R6: Writing 0x0B to the command address makes later command-address reads return the in-service register. Writing 0x0A makes them return the pending register.
- R7: Writing 0x20 to the command address (end of interrupt) clears the highest-priority set in-service bit.
- R8: A command-address byte with bit 4 set is the initialization byte. It clears the mask to 0x00, clears the in-service register, selects pending-register reads, and loads base from bits 7:5.
- R9: After a mask write, `intr` stays low until the cycle after the first `instrBoundary` pulse that is sampled after the write's clock edge.
- R10: A write to the mask address sets the mask, and a read of the mask address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Interrupt request lines, edge sensitive |
| cpuSel | input | 1 | Port address: 0 command, 1 mask |
| cpuWr | input | 1 | Write strobe, one cycle per byte |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data for the selected address |
| instrBoundary | input | 1 | One-cycle pulse at each CPU instruction boundary |
| intAck | input | 1 | One-cycle interrupt acknowledge |
| intr | output | 1 | Interrupt request to the CPU |
| vector | output | 8 | Vector captured at the last acknowledge |

## Verification
A directed sequence checks the following cases:
- a request that is masked while it arrives, then unmasked by a mask write with and without the boundary pulse;
- a lower level arriving while a higher level is in service, then a higher one arriving;
- two end-of-interrupt commands;
- a spurious acknowledge;
- a line held high across its own acknowledge.

These cases separate edge latching from level sensing, nested priority from plain priority, and the boundary hold from immediate assertion. A random phase then mixes request toggles, mask writes, boundaries, acknowledges, read-select commands and end-of-interrupt commands. A behavioural model compares `intr`, `vector` and the read data against the design on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LINES  = 8;
  localparam int LVL_W  = $clog2(LINES);
  localparam int DW     = 8;
  localparam int BASE_W = 3;
  localparam int PAD_W  = DW - BASE_W - LVL_W;
  localparam logic [DW-1:0] EOI_CMD = 8'h20;

  typedef struct packed {
    logic          maskWr;
    logic          initWr;
    logic          eoi;
    logic          ack;
    logic [DW-1:0] data;
  } strobes_t;
endpackage

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqIn,
  input  strobes_t         strb,
  output logic [LINES-1:0] irrQ,
  output logic [LINES-1:0] imrQ,
  output logic [LINES-1:0] isrQ,
  output logic             winValid,
  output logic [DW-1:0]    vector
);
  logic [LINES-1:0]  reqPrevQ, rise, eligible, ackSet, eoiClr;
  logic [LVL_W-1:0]  winLevel, isrLevel;
  logic              winFound, isrFound;
  logic [BASE_W-1:0] baseQ;

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_edge
      assign rise[gi] = reqIn[gi] & ~reqPrevQ[gi];
      assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
        $rose(reqIn[gi]) |=> irrQ[gi]);
    end
  endgenerate

  assign eligible = irrQ & ~imrQ;

  always_comb begin
    winFound = 1'b0;
    winLevel = '0;
    isrFound = 1'b0;
    isrLevel = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winFound = 1'b1;
        winLevel = LVL_W'(i);
      end
      if (isrQ[i]) begin
        isrFound = 1'b1;
        isrLevel = LVL_W'(i);
      end
    end
  end

  assign winValid = winFound && (!isrFound || (winLevel < isrLevel));
  assign ackSet   = (strb.ack && winValid) ? (LINES'(1) << winLevel) : '0;
  assign eoiClr   = (strb.eoi && isrFound) ? (LINES'(1) << isrLevel) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrevQ <= '0;
      irrQ     <= '0;
      imrQ     <= '1;
      isrQ     <= '0;
      baseQ    <= '0;
      vector   <= '0;
    end else begin
      reqPrevQ <= reqIn;
      irrQ     <= (irrQ & ~ackSet) | rise;
      if (strb.initWr) begin
        isrQ  <= '0;
        imrQ  <= '0;
        baseQ <= strb.data[DW-1 -: BASE_W];
      end else begin
        isrQ <= (isrQ & ~eoiClr) | ackSet;
        if (strb.maskWr) imrQ <= strb.data;
      end
      if (strb.ack)
        vector <= {baseQ, {PAD_W{1'b0}}, (winValid ? winLevel : LVL_W'(LINES - 1))};
    end
  end

  assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && winValid && !strb.initWr) |=> isrQ[$past(winLevel)]);

  assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !strb.ack && (isrQ != '0)) |=> ($countones(isrQ) == $countones($past(isrQ)) - 1));

  assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.initWr |=> ((isrQ == '0) && (imrQ == '0)));
endmodule

// File: rtl/irq_ctrl_control.sv
module irq_ctrl_control
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuSel,
  input  logic             cpuWr,
  input  logic [DW-1:0]    cpuWrData,
  input  logic             instrBoundary,
  input  logic             intAck,
  input  logic             winValid,
  input  logic [LINES-1:0] irrQ,
  input  logic [LINES-1:0] imrQ,
  input  logic [LINES-1:0] isrQ,
  output strobes_t         strb,
  output logic             intr,
  output logic [DW-1:0]    cpuRdData
);
  logic cmdWr, holdQ, selIsrQ, selCmd;

  assign cmdWr = cpuWr & ~cpuSel;

  always_comb begin
    strb.data   = cpuWrData;
    strb.maskWr = cpuWr & cpuSel;
    strb.initWr = cmdWr & cpuWrData[4];
    strb.eoi    = cmdWr & ~cpuWrData[4] & ~cpuWrData[3] & (cpuWrData == EOI_CMD);
    strb.ack    = intAck;
  end

  assign selCmd = cmdWr & ~cpuWrData[4] & cpuWrData[3] & cpuWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ   <= 1'b0;
      selIsrQ <= 1'b0;
    end else begin
      if (strb.maskWr)       holdQ <= 1'b1;
      else if (instrBoundary) holdQ <= 1'b0;
      if (strb.initWr)  selIsrQ <= 1'b0;
      else if (selCmd)  selIsrQ <= cpuWrData[0];
    end
  end

  assign intr      = winValid & ~holdQ;
  assign cpuRdData = cpuSel ? imrQ : (selIsrQ ? isrQ : irrQ);

  assert_hold_after_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> !intr);

  assert_mask_readback_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskWr && !intAck) |=> (imrQ == $past(cpuWrData)));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    reqIn,
  input  logic          cpuSel,
  input  logic          cpuWr,
  input  logic [7:0]    cpuWrData,
  output logic [7:0]    cpuRdData,
  input  logic          instrBoundary,
  input  logic          intAck,
  output logic          intr,
  output logic [7:0]    vector
);
  strobes_t         strb;
  logic [LINES-1:0] irrQ, imrQ, isrQ;
  logic             winValid;

  irq_ctrl_control u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuWrData(cpuWrData),
    .instrBoundary(instrBoundary), .intAck(intAck), .winValid(winValid),
    .irrQ(irrQ), .imrQ(imrQ), .isrQ(isrQ), .strb(strb), .intr(intr),
    .cpuRdData(cpuRdData)
  );

  irq_ctrl_datapath u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strb(strb), .irrQ(irrQ), .imrQ(imrQ),
    .isrQ(isrQ), .winValid(winValid), .vector(vector)
  );
endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       cpuSel = 1'b0;
  logic       cpuWr = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic       instrBoundary = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] cpuRdData, vector;
  logic       intr;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .instrBoundary(instrBoundary),
    .intAck(intAck), .intr(intr), .vector(vector)
  );

  // behavioural reference model
  logic [7:0] mIrr, mImr, mIsr, mPrev, mVec;
  logic [2:0] mBase;
  logic       mSelIsr, mHold;

  function automatic int firstSet(input logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic modelIntr();
    return (firstSet(mIrr & ~mImr) < firstSet(mIsr)) && !mHold;
  endfunction

  function automatic logic [7:0] modelRead();
    if (cpuSel) return mImr;
    return mSelIsr ? mIsr : mIrr;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nIrr, nIsr, nImr;
    int w, t;
    if (!rstN) begin
      mIrr <= '0; mImr <= 8'hFF; mIsr <= '0; mPrev <= '0; mVec <= '0;
      mBase <= '0; mSelIsr <= 1'b0; mHold <= 1'b0;
    end else begin
      w = firstSet(mIrr & ~mImr);
      t = firstSet(mIsr);
      nIrr = mIrr; nIsr = mIsr; nImr = mImr;
      if (intAck) begin
        if (w < t) begin
          nIrr[w] = 1'b0;
          nIsr[w] = 1'b1;
          mVec <= {mBase, 2'b00, 3'(w)};
        end else begin
          mVec <= {mBase, 2'b00, 3'd7};
        end
      end
      if (cpuWr && cpuSel) begin
        nImr = cpuWrData;
        mHold <= 1'b1;
      end else if (instrBoundary) begin
        mHold <= 1'b0;
      end
      if (cpuWr && !cpuSel) begin
        if (cpuWrData[4]) begin
          nImr = '0; nIsr = '0; mBase <= cpuWrData[7:5]; mSelIsr <= 1'b0;
        end else if (cpuWrData[3]) begin
          if (cpuWrData[1]) mSelIsr <= cpuWrData[0];
        end else if (cpuWrData == 8'h20 && t < 8) begin
          nIsr[t] = 1'b0;
        end
      end
      nIrr = nIrr | (reqIn & ~mPrev);
      mPrev <= reqIn;
      mIrr <= nIrr; mIsr <= nIsr; mImr <= nImr;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R4 R5 R9 R10 R6 via read data)
  always @(negedge clk) begin
    if (rstN) begin
      #1;
      chk({7'd0, intr}, {7'd0, modelIntr()}, "R4/R9 intr vs model");
      chk(vector, mVec, "R5 vector vs model");
      chk(cpuRdData, modelRead(), "R6/R10 read data vs model");
    end
  end

  task automatic cpuWrite(input logic sel, input logic [7:0] d);
    cpuSel = sel; cpuWrData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic pulseBoundary();
    instrBoundary = 1'b1;
    @(negedge clk);
    instrBoundary = 1'b0;
  endtask

  task automatic pulseAck();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic readChk(input logic sel, input logic [7:0] exp, input string tag);
    cpuSel = sel;
    #1 chk(cpuRdData, exp, tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk(1'b1, 8'hFF, "R1 mask after reset");
    readChk(1'b0, 8'h00, "R1 pending after reset");
    chk({7'd0, intr}, 8'h00, "R1 intr after reset");
    @(negedge clk);
    // R8 init: base 101
    cpuWrite(1'b0, 8'hB0);
    readChk(1'b1, 8'h00, "R8 init clears mask");
    @(negedge clk);
    cpuWrite(1'b1, 8'hFF);
    readChk(1'b1, 8'hFF, "R10 mask readback");
    pulseBoundary();
    // R2 masked edge latched
    reqIn[1] = 1'b1;
    @(negedge clk);
    readChk(1'b0, 8'h02, "R2 masked edge latched");
    chk({7'd0, intr}, 8'h00, "R3 masked request silent");
    @(negedge clk);
    // R9 unmask: held until a boundary
    cpuWrite(1'b1, 8'h00);
    readChk(1'b1, 8'h00, "R9 immediate readback");
    chk({7'd0, intr}, 8'h00, "R9 intr held after mask write");
    @(negedge clk);
    chk({7'd0, intr}, 8'h00, "R9 intr held without boundary");
    pulseBoundary();
    #1 chk({7'd0, intr}, 8'h01, "R3 unmasked request fires");
    @(negedge clk);
    // R5 acknowledge
    pulseAck();
    #1 chk(vector, 8'hA1, "R5 vector level 1");
    chk({7'd0, intr}, 8'h00, "R5 intr drops after ack");
    cpuWrite(1'b0, 8'h0B);
    readChk(1'b0, 8'h02, "R6 isr select");
    @(negedge clk);
    // R4 nesting
    reqIn[3] = 1'b1;
    @(negedge clk);
    #1 chk({7'd0, intr}, 8'h00, "R4 lower level blocked by in-service");
    reqIn[0] = 1'b1;
    @(negedge clk);
    #1 chk({7'd0, intr}, 8'h01, "R4 higher level preempts");
    @(negedge clk);
    pulseAck();
    #1 chk(vector, 8'hA0, "R5 vector level 0");
    readChk(1'b0, 8'h03, "R5 two in service");
    @(negedge clk);
    // R7 EOI
    cpuWrite(1'b0, 8'h20);
    readChk(1'b0, 8'h02, "R7 EOI clears level 0");
    @(negedge clk);
    cpuWrite(1'b0, 8'h20);
    readChk(1'b0, 8'h00, "R7 EOI clears level 1");
    chk({7'd0, intr}, 8'h01, "R4 level 3 now eligible");
    @(negedge clk);
    pulseAck();
    #1 chk(vector, 8'hA3, "R5 vector level 3");
    @(negedge clk);
    pulseAck();
    #1 chk(vector, 8'hA7, "R5 spurious vector");
    readChk(1'b0, 8'h08, "R5 spurious leaves in-service");
    @(negedge clk);
    // R6 back to pending; R2 held line not re-latched
    cpuWrite(1'b0, 8'h0A);
    readChk(1'b0, 8'h00, "R2 held line not re-latched");
    @(negedge clk);
    reqIn[1] = 1'b0;
    @(negedge clk);
    reqIn[1] = 1'b1;
    @(negedge clk);
    readChk(1'b0, 8'h02, "R2 new edge latched");
    chk({7'd0, intr}, 8'h01, "R4 level 1 above level 3");
    @(negedge clk);
    // R8 init releases stuck in-service
    cpuWrite(1'b0, 8'h50);
    cpuWrite(1'b0, 8'h0B);
    readChk(1'b0, 8'h00, "R8 init clears in-service");
    @(negedge clk);
    pulseAck();
    #1 chk(vector, 8'h41, "R8 new base in vector");
    @(negedge clk);
    // random phase, compared every clock
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 3) == 0) reqIn[$urandom_range(0, 7)] ^= 1'b1;
      instrBoundary = ($urandom_range(0, 2) == 0);
      intAck = (r < 12);
      cpuWr = 1'b0;
      cpuSel = $urandom_range(0, 1);
      if (r >= 80 && r < 88) begin
        cpuWr = 1'b1; cpuSel = 1'b1; cpuWrData = 8'($urandom());
      end else if (r >= 88 && r < 94) begin
        cpuWr = 1'b1; cpuSel = 1'b0; cpuWrData = 8'h20;
      end else if (r >= 94) begin
        cpuWr = 1'b1; cpuSel = 1'b0; cpuWrData = ($urandom_range(0, 1) != 0) ? 8'h0B : 8'h0A;
      end
      @(negedge clk);
    end
    cpuWr = 1'b0; intAck = 1'b0; instrBoundary = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule